// File: doc/BRIEF.md
# Residue-Quotient Checked Sum-of-Absolute-Differences Unit

This block computes the sum of absolute differences (SAD) between a 4x4 block of current pixels and a 4x4 block of reference pixels. It uses a single processing element that takes one pixel pair per clock, so one block costs 16 accepted pixel cycles. The SAD measures how closely a candidate block matches, and a motion search compares these sums.

A test code generator runs next to the processing element and builds its own code for the expected sum. It works from a separately formed absolute difference and keeps the sum as a residue and a quotient modulo 64. When the block ends, the accumulator's result is encoded the same way and the two codes are compared. If they differ, the error flag rises and the corrected output takes the value rebuilt from the generator's code, which is quotient times 64 plus residue. A fault mask input corrupts the accumulator on purpose so that the checking path can be exercised.

Top module: `rq_sad_unit`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `done_o` and `err_o` are 0 and `sad_o`, `sad_raw_o`, `res_o` and `quo_o` are 0.
- R2: A block starts with a pixel for which both `pix_valid_i` and `start_i` are 1. After the 16th accepted pixel, `done_o` is 1 for exactly one cycle, the cycle that follows the clock edge that captured that pixel. In that cycle, `sad_o` equals the sum of |cur - ref| over the 16 pixels.
- R3: In the `done_o` cycle of a block that had no injected fault, `err_o` is 0 and `sad_o` equals `sad_raw_o`.
- R4: A nonzero `fault_mask_i` that comes with an accepted pixel is XORed into the accumulator after that pixel's difference is added. `sad_raw_o` then shows the corrupted sum modulo 4096, and `err_o` is 1 in the `done_o` cycle whenever the residue or the quotient of the two codes differs.
- R5: When `err_o` is 1, `sad_o` equals `quo_o`*64 + `res_o`, which is the fault-free SAD.
- R6: In the `done_o` cycle, `res_o` equals the true SAD modulo 64 and `quo_o` equals the true SAD divided by 64 and rounded down. This holds even when the fault mask hits the block's first pixel.
- R7: A `start_i` pixel that arrives in the middle of a block discards the partial block. The accumulator and both codes restart from that pixel.
- R8: Pixels with `pix_valid_i` at 1 and `start_i` at 0, arriving while no block is open, are ignored. They do not change the next block's results and do not raise `done_o`.
- R9: Cycles in which `pix_valid_i` is 0 inside a block leave the result unchanged. `err_o` is never 1 outside a `done_o` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | A pixel pair is present this cycle |
| start_i | input | 1 | The present pixel is the first of a block |
| cur_px_i | input | 8 | Current-frame pixel |
| ref_px_i | input | 8 | Reference-block pixel |
| fault_mask_i | input | 12 | Bits flipped in the accumulator on this pixel |
| done_o | output | 1 | Result strobe, one cycle |
| err_o | output | 1 | Code mismatch detected (valid with done_o) |
| sad_o | output | 12 | Corrected SAD |
| sad_raw_o | output | 12 | Accumulator output of the processing element |
| res_o | output | 6 | Generator residue, SAD mod 64 |
| quo_o | output | 6 | Generator quotient, SAD / 64 |

## Verification
Two events can share one cycle. The result strobe with its error judgement and correction can coincide with the first pixel of the next block, because a new `start_i` may arrive in the very cycle `done_o` is high. The bench makes this happen by running a faulted block straight into a clean one with no idle cycle between them. It reads the first block's outputs one nanosecond after the edge that ends the block, before that cycle's new inputs are applied. It then confirms that the second block's strobe reports its own clean sum with no error left over from the first. Faults are also placed on the first pixel, together with `start_i`, and on the last pixel, together with the strobe-producing edge.

// File: rtl/rq_sad_pkg.sv
package rq_sad_pkg;
  localparam int unsigned PIX_W = 8;
  localparam int unsigned N_PIX = 16;
  localparam int unsigned MOD_W = 6;
  localparam int unsigned SAD_W = PIX_W + $clog2(N_PIX);
  localparam int unsigned Q_W   = SAD_W - MOD_W;

  typedef struct packed {
    logic [Q_W-1:0]   quo;
    logic [MOD_W-1:0] res;
  } rq_code_t;
endpackage

// File: rtl/sad_pe.sv
module sad_pe
  import rq_sad_pkg::*;
#(
  parameter int unsigned PW = PIX_W,
  parameter int unsigned SW = SAD_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic          first_i,
  input  logic [PW-1:0] cur_px_i,
  input  logic [PW-1:0] ref_px_i,
  input  logic [SW-1:0] fault_mask_i,
  output logic [SW-1:0] acc_o
);
  logic signed [PW:0] diff;
  logic [PW-1:0]      ad;
  logic [SW-1:0]      base, sum, acc_q;

  // signed difference then magnitude
  assign diff = $signed({1'b0, cur_px_i}) - $signed({1'b0, ref_px_i});
  assign ad   = diff[PW] ? PW'(-diff) : diff[PW-1:0];
  assign base = first_i ? '0 : acc_q;
  assign sum  = base + SW'(ad);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (take_i) acc_q <= sum ^ fault_mask_i;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/rq_tcg.sv
module rq_tcg
  import rq_sad_pkg::*;
#(
  parameter int unsigned PW = PIX_W,
  parameter int unsigned MW = MOD_W,
  parameter int unsigned QW = Q_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic          first_i,
  input  logic [PW-1:0] cur_px_i,
  input  logic [PW-1:0] ref_px_i,
  output rq_code_t      code_o
);
  localparam int unsigned ADQ_W = PW - MW;

  logic [PW-1:0]    ad;
  logic [MW-1:0]    ad_r, res_base, res_q;
  logic [ADQ_W-1:0] ad_q;
  logic [QW-1:0]    quo_base, quo_q;
  logic [MW:0]      sum_r;

  // magnitude by compare-and-swap, separate from the PE's form
  assign ad       = (cur_px_i >= ref_px_i) ? cur_px_i - ref_px_i : ref_px_i - cur_px_i;
  assign ad_r     = ad[MW-1:0];
  assign ad_q     = ad[PW-1:MW];
  assign res_base = first_i ? '0 : res_q;
  assign quo_base = first_i ? '0 : quo_q;
  assign sum_r    = {1'b0, res_base} + {1'b0, ad_r};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      quo_q <= '0;
    end else if (take_i) begin
      res_q <= sum_r[MW-1:0];
      quo_q <= quo_base + QW'(ad_q) + QW'(sum_r[MW]);
    end
  end

  assign code_o.res = res_q;
  assign code_o.quo = quo_q;
endmodule

// File: rtl/rq_encode.sv
module rq_encode
  import rq_sad_pkg::*;
#(
  parameter int unsigned SW = SAD_W,
  parameter int unsigned MW = MOD_W
) (
  input  logic [SW-1:0] val_i,
  output rq_code_t      code_o
);
  assign code_o.res = val_i[MW-1:0];
  assign code_o.quo = val_i[SW-1:MW];
endmodule

// File: rtl/rq_judge.sv
module rq_judge
  import rq_sad_pkg::*;
#(
  parameter int unsigned SW = SAD_W,
  parameter int unsigned MW = MOD_W
) (
  input  logic          eval_i,
  input  rq_code_t      gen_code_i,
  input  rq_code_t      pe_code_i,
  input  logic [SW-1:0] pe_val_i,
  output logic          err_o,
  output logic [SW-1:0] sad_o
);
  logic          mismatch;
  logic [SW-1:0] recovered;

  assign mismatch  = (gen_code_i.res != pe_code_i.res) | (gen_code_i.quo != pe_code_i.quo);
  assign err_o     = eval_i & mismatch;
  assign recovered = SW'(gen_code_i.quo) * SW'(1 << MW) + SW'(gen_code_i.res);
  assign sad_o     = err_o ? recovered : pe_val_i;
endmodule

// File: rtl/rq_sad_unit.sv
module rq_sad_unit
  import rq_sad_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pix_valid_i,
  input  logic             start_i,
  input  logic [PIX_W-1:0] cur_px_i,
  input  logic [PIX_W-1:0] ref_px_i,
  input  logic [SAD_W-1:0] fault_mask_i,
  output logic             done_o,
  output logic             err_o,
  output logic [SAD_W-1:0] sad_o,
  output logic [SAD_W-1:0] sad_raw_o,
  output logic [MOD_W-1:0] res_o,
  output logic [Q_W-1:0]   quo_o
);
  localparam int unsigned CNT_W = $clog2(N_PIX);

  logic             busy_q, done_q, take, first, last;
  logic [CNT_W-1:0] cnt_q;
  logic [SAD_W-1:0] acc, fault_gated;
  rq_code_t         gen_code, pe_code;

  assign first       = pix_valid_i & start_i;
  assign take        = pix_valid_i & (start_i | busy_q);
  assign last        = take & ~first & (cnt_q == CNT_W'(N_PIX - 1));
  assign fault_gated = take ? fault_mask_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (first) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(1);
      end else if (take) begin
        cnt_q  <= cnt_q + CNT_W'(1);
        if (last) busy_q <= 1'b0;
      end
    end
  end

  sad_pe u_pe (
    .clk_i, .rst_ni, .take_i(take), .first_i(first),
    .cur_px_i, .ref_px_i, .fault_mask_i(fault_gated), .acc_o(acc)
  );

  rq_tcg u_tcg (
    .clk_i, .rst_ni, .take_i(take), .first_i(first),
    .cur_px_i, .ref_px_i, .code_o(gen_code)
  );

  rq_encode u_enc (.val_i(acc), .code_o(pe_code));

  rq_judge u_judge (
    .eval_i(done_q), .gen_code_i(gen_code), .pe_code_i(pe_code),
    .pe_val_i(acc), .err_o(err_o), .sad_o(sad_o)
  );

  assign done_o    = done_q;
  assign sad_raw_o = acc;
  assign res_o     = gen_code.res;
  assign quo_o     = gen_code.quo;
endmodule

// File: rtl/rq_sad_checks.sv
module rq_sad_checks
  import rq_sad_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             done_o,
  input logic             err_o,
  input logic [SAD_W-1:0] sad_o,
  input logic [SAD_W-1:0] sad_raw_o,
  input logic [MOD_W-1:0] res_o,
  input logic [Q_W-1:0]   quo_o
);
  always_comb begin
    if (!rst_ni) begin
      a_r1_reset_quiet: assert (!done_o && !err_o);
    end
  end

  a_r2_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  a_r3_clean_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (sad_o == sad_raw_o));

  a_r4_mismatch_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (sad_raw_o != {quo_o, res_o})) |-> err_o);

  a_r5_recovered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (sad_o == {quo_o, res_o}));
endmodule

bind rq_sad_unit rq_sad_checks u_checks (
  .clk_i(clk_i), .rst_ni(rst_ni), .done_o(done_o), .err_o(err_o),
  .sad_o(sad_o), .sad_raw_o(sad_raw_o), .res_o(res_o), .quo_o(quo_o)
);

// File: tb/tb_rq_sad_unit.sv
`timescale 1ns/1ps
module tb_rq_sad_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pix_valid_i = 1'b0, start_i = 1'b0;
  logic [7:0]  cur_px_i = '0, ref_px_i = '0;
  logic [11:0] fault_mask_i = '0;
  logic        done_o, err_o;
  logic [11:0] sad_o, sad_raw_o;
  logic [5:0]  res_o, quo_o;

  int checks = 0, errors = 0;
  int exp_sad = 0, exp_raw = 0;
  bit exp_err = 0, exp_pending = 0;

  always #2.5 clk = ~clk;

  rq_sad_unit dut (.clk_i(clk), .*);

  typedef struct packed {
    logic [7:0]  cb, cs, rb, rs;
    logic [3:0]  fpix;
    logic [11:0] fmask;
    logic        gap;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'd0,   8'd0,  8'd0,   8'd0, 4'd0,  12'h000, 1'b0},  // zero SAD
    '{8'd255, 8'd0,  8'd0,   8'd0, 4'd0,  12'h000, 1'b0},  // max SAD 4080
    '{8'd10,  8'd7,  8'd200, 8'd3, 4'd0,  12'h000, 1'b1},  // mixed, with gaps
    '{8'd10,  8'd7,  8'd200, 8'd3, 4'd5,  12'h001, 1'b0},  // residue fault
    '{8'd0,   8'd16, 8'd255, 8'd0, 4'd15, 12'h800, 1'b0},  // fault on last pixel
    '{8'd100, 8'd1,  8'd100, 8'd1, 4'd0,  12'h040, 1'b0},  // quotient fault on first
    '{8'd3,   8'd29, 8'd90,  8'd11, 4'd9, 12'hA5A, 1'b1}   // multi-bit fault, gaps
  };

  function automatic logic [7:0] px(input logic [7:0] b, input logic [7:0] s, input int k);
    return 8'((int'(b) + int'(s) * k) % 256);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_expect(input vec_t v);
    int s = 0, r = 0;
    for (int k = 0; k < 16; k++) begin
      int c = px(v.cb, v.cs, k), f = px(v.rb, v.rs, k);
      int ad = (c > f) ? c - f : f - c;
      s += ad;
      r = ((r + ad) & 12'hFFF) ^ ((k == int'(v.fpix)) ? int'(v.fmask) : 0);
    end
    exp_sad = s; exp_raw = r; exp_err = (v.fmask != 0); exp_pending = 1;
  endtask

  // drives 'npix' pixels of v; sets expectation when 'expect_it'
  task automatic drive(input vec_t v, input int npix, input bit expect_it);
    for (int k = 0; k < npix; k++) begin
      if (v.gap && (k % 5 == 2)) begin
        @(negedge clk);
        pix_valid_i = 0; start_i = 0; fault_mask_i = '0;
        cur_px_i = 8'hFF; ref_px_i = 8'h00;
      end
      @(negedge clk);
      if (k == 0 && expect_it) set_expect(v);
      pix_valid_i  = 1;
      start_i      = (k == 0);
      cur_px_i     = px(v.cb, v.cs, k);
      ref_px_i     = px(v.rb, v.rs, k);
      fault_mask_i = (k == int'(v.fpix)) ? v.fmask : '0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pix_valid_i = 0; start_i = 0; fault_mask_i = '0;
    end
  endtask

  // sample 1 ns after each rising edge, before the negedge drive
  always @(posedge clk) begin
    #1;
    if (rst_ni && done_o) begin
      if (!exp_pending) chk("R2 unexpected done_o", 1, 0);
      else begin
        chk(exp_err ? "R5 recovered sad_o" : "R2 sad_o", int'(sad_o), exp_sad);
        chk(exp_err ? "R4 err_o raised" : "R3 err_o clear", int'(err_o), int'(exp_err));
        chk("R4 sad_raw_o", int'(sad_raw_o), exp_raw);
        chk("R6 res_o", int'(res_o), exp_sad % 64);
        chk("R6 quo_o", int'(quo_o), exp_sad / 64);
        exp_pending = 0;
      end
    end else if (rst_ni && err_o) begin
      chk("R9 err_o outside done", 1, 0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done_o in reset", int'(done_o), 0);
    chk("R1 err_o in reset", int'(err_o), 0);
    chk("R1 sad_o in reset", int'(sad_o), 0);
    rst_ni = 1;
    @(negedge clk);
    chk("R1 outputs after release", int'({done_o, err_o, sad_o, res_o, quo_o}), 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i], 16, 1);
      idle(3);
      chk("R2 done strobe seen", int'(exp_pending), 0);
    end

    // R8: stray pixels with no open block are ignored
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      pix_valid_i = 1; start_i = 0; cur_px_i = 8'd200; ref_px_i = 8'd1;
      fault_mask_i = 12'hFFF;
    end
    idle(2);
    chk("R8 no done from stray pixels", int'(done_o), 0);
    drive(VECS[0], 16, 1);
    idle(3);
    chk("R8 block after stray pixels done", int'(exp_pending), 0);

    // R7: restart mid-block
    drive(VECS[1], 7, 0);
    drive(VECS[2], 16, 1);
    idle(3);
    chk("R7 restart result seen", int'(exp_pending), 0);

    // back-to-back: faulted block then clean block starting in the done cycle
    drive(VECS[4], 16, 1);
    drive(VECS[2], 16, 1);
    idle(3);
    chk("R3 clean block after faulted one", int'(exp_pending), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule